// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter with a programmable prescaler and four match comparators. While the timer is enabled, a prescale counter advances on every clock. Each time it completes a prescale period, the timer count advances by one. Every comparator watches the timer count at all times. At the end of a prescale period in which the count equals a comparator's value, a match event occurs. Each comparator has three control bits of its own. They can latch an interrupt flag, restart the count from zero, or halt the timer by clearing its enable bit, in any combination.

Software reaches every register through a single-cycle word interface: a 4-bit word address, a write strobe and write data. The read data is combinational from the address. The interrupt output is a level signal that stays high while any flag is set. A typical use is a periodic interrupt: the match value sets the period, and interrupt plus restart are set on that comparator. Another use is a one-shot delay: a comparator with interrupt plus halt.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads 0, and `irq` is 0.
- R2: While enable (control bit 0) is 1 and counter-clear (control bit 1) is 0, the prescale counter (address 4) counts from 0 up to the prescale value (address 2), then returns to 0 on the next clock. On that same clock the timer count (address 3) increments by one. The clock on which the prescale counter is at or above the prescale value is called a tick.
- R3: While enable is 0 and counter-clear is 0, both counters keep their values.
- R4: While counter-clear is 1, both counters are loaded with 0 on every clock, and no match event occurs.
- R5: A match event for comparator n (n = 0..3, value at address 8+n) occurs on a tick when the timer count equals its value. If match-control bit 3n is 1, the event sets flag n (address 5, bit n).
- R6: If a match event for comparator n has match-control bit 3n+1 set, the timer count becomes 0 on that tick instead of incrementing.
- R7: If a match event has match-control bit 3n+2 set, the timer count keeps its value, the prescale counter returns to 0, and enable is cleared. This clearing wins over a control write on the same clock.
- R8: When several match events occur on one tick, their actions combine. Any restart makes the count 0, even when a halt occurs too. Any halt clears enable.
- R9: Flags are sticky. Writing 1 to bit n of address 5 clears flag n, but a match event on the same clock keeps it set. `irq` is 1 exactly when some flag is 1.
- R10: The match-control register (address 1) holds 12 bits. Write data bits 31:12 are ignored, and those bits read as 0.
- R11: Addresses 0, 1, 2, 8-11 are writable. Addresses 3 and 4 are read-only. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | OR of all match flags |

## Verification
On every cycle, assertions check several behaviours. The counters must hold while the timer is disabled and must be zero after a counter-clear. The prescale counter must stay within the prescale value. A restart match must leave the count at zero, and a halt match must drop the enable bit. Flags must not vanish without a clearing write, and the upper match-control bits must read as zero. Other behaviours can only be shown by the bench's scenarios, run against a cycle-level reference model: the exact period produced by a prescale and match setting, the combination of simultaneous matches, and the priority of a flag set over a clear on one clock.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W  = 32,
  parameter int NM = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  output logic         irq
);
  localparam int CW = 3 * NM;

  logic [1:0]    ctrl;
  logic [CW-1:0] mctl;
  logic [W-1:0]  pr, tc, pc;
  logic [W-1:0]  mr [NM];
  logic [NM-1:0] flg, ev, ibit, rbit, sbit, clr;

  wire run      = ctrl[0] & ~ctrl[1];
  wire tick     = run && (pc >= pr);
  wire any_rst  = |(ev & rbit);
  wire any_stop = |(ev & sbit);

  assign clr = (reg_wr && reg_addr == 4'd5) ? reg_wdata[NM-1:0] : '0;
  assign irq = |flg;

  for (genvar n = 0; n < NM; n++) begin : g_cmp
    assign ibit[n] = mctl[3*n];
    assign rbit[n] = mctl[3*n+1];
    assign sbit[n] = mctl[3*n+2];
    assign ev[n]   = tick && (tc == mr[n]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mr[n] <= '0;
      else if (reg_wr && reg_addr == 4'(8 + n)) mr[n] <= reg_wdata[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mctl <= '0;
      pr   <= '0;
      tc   <= '0;
      pc   <= '0;
      flg  <= '0;
    end else begin
      if (reg_wr && reg_addr == 4'd0) ctrl <= reg_wdata[1:0];
      if (any_stop) ctrl[0] <= 1'b0;
      if (reg_wr && reg_addr == 4'd1) mctl <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == 4'd2) pr <= reg_wdata[W-1:0];
      flg <= (flg & ~clr) | (ev & ibit);
      if (ctrl[1]) pc <= '0;
      else if (run) pc <= tick ? '0 : pc + 1'b1;
      if (ctrl[1]) tc <= '0;
      else if (tick) tc <= any_rst ? '0 : (any_stop ? tc : tc + 1'b1);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0: reg_rdata[1:0]    = ctrl;
      4'd1: reg_rdata[CW-1:0] = mctl;
      4'd2: reg_rdata[W-1:0]  = pr;
      4'd3: reg_rdata[W-1:0]  = tc;
      4'd4: reg_rdata[W-1:0]  = pc;
      4'd5: reg_rdata[NM-1:0] = flg;
      default: ;
    endcase
    for (int n = 0; n < NM; n++)
      if (reg_addr == 4'(8 + n)) reg_rdata[W-1:0] = mr[n];
  end

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !ctrl[1]) |=> ($stable(tc) && $stable(pc)));

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[1] |=> (tc == '0 && pc == '0));

  a_r2_pc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pc <= pr) |=> (pc <= $past(pr)));

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    any_rst |=> (tc == '0));

  a_r7_halt_disables: assert property (@(posedge clk) disable iff (!rst_n)
    any_stop |=> !ctrl[0]);

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flg & ~clr) & ~flg) == '0));

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 4'd1) |-> (reg_rdata[31:CW] == '0));
endmodule

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  always #2 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [1:0]  m_ctrl;
  logic [11:0] m_mctl;
  logic [31:0] m_pr, m_tc, m_pc;
  logic [31:0] m_mr [4];
  logic [3:0]  m_flg;

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, m_ctrl};
      4'd1: return {20'd0, m_mctl};
      4'd2: return m_pr;
      4'd3: return m_tc;
      4'd4: return m_pc;
      4'd5: return {28'd0, m_flg};
      4'd8, 4'd9, 4'd10, 4'd11: return m_mr[a - 4'd8];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R7";
      4'd1: return "R10";
      4'd3, 4'd4: return "R2";
      4'd5: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_mctl = '0; m_pr = '0; m_tc = '0; m_pc = '0; m_flg = '0;
    for (int n = 0; n < 4; n++) m_mr[n] = '0;
  endtask

  task automatic cyc(input logic [3:0] a, input logic we, input logic [31:0] wd, input string tag);
    logic run, tick, any_rst, any_stop;
    logic [3:0] ev, clr;
    logic [1:0] n_ctrl;
    logic [31:0] n_tc, n_pc;
    @(negedge clk);
    reg_addr = a; reg_wr = we; reg_wdata = wd;
    #1;
    check(tag == "" ? tag_of(a) : tag, reg_rdata, model_rd(a));
    check("R9", {31'd0, irq}, {31'd0, |m_flg});
    run  = m_ctrl[0] && !m_ctrl[1];
    tick = run && (m_pc >= m_pr);
    for (int n = 0; n < 4; n++) ev[n] = tick && (m_tc == m_mr[n]);
    any_rst = 0; any_stop = 0;
    for (int n = 0; n < 4; n++) begin
      if (ev[n] && m_mctl[3*n+1]) any_rst = 1;
      if (ev[n] && m_mctl[3*n+2]) any_stop = 1;
    end
    clr = (we && a == 4'd5) ? wd[3:0] : 4'd0;
    n_ctrl = (we && a == 4'd0) ? wd[1:0] : m_ctrl;
    if (any_stop) n_ctrl[0] = 1'b0;
    n_pc = m_ctrl[1] ? 32'd0 : (run ? (tick ? 32'd0 : m_pc + 1) : m_pc);
    n_tc = m_ctrl[1] ? 32'd0 : (tick ? (any_rst ? 32'd0 : (any_stop ? m_tc : m_tc + 1)) : m_tc);
    @(posedge clk);
    for (int n = 0; n < 4; n++) begin
      if (ev[n] && m_mctl[3*n]) m_flg[n] = 1'b1;
      else if (clr[n]) m_flg[n] = 1'b0;
    end
    if (we && a == 4'd1) m_mctl = wd[11:0];
    if (we && a == 4'd2) m_pr = wd;
    if (we && a >= 4'd8 && a <= 4'd11) m_mr[a - 4'd8] = wd;
    m_ctrl = n_ctrl; m_tc = n_tc; m_pc = n_pc;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(a, 1'b1, d, "");
  endtask

  task automatic run_rd(input int cycles, input logic [3:0] a, input string tag);
    for (int i = 0; i < cycles; i++) cyc(a, 1'b0, 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state on every address
    for (int a = 0; a < 16; a++) cyc(4'(a), 1'b0, 32'd0, "R1");

    // R10: upper match-control bits dropped
    wr(4'd1, 32'hFFFF_FFFF);
    cyc(4'd1, 1'b0, 32'd0, "R10");
    wr(4'd1, 32'd0);

    // R6: periodic restart at 5 with prescale 2, interrupt on comparator 0
    wr(4'd2, 32'd2);
    wr(4'd8, 32'd5);
    wr(4'd1, 32'b011);
    wr(4'd0, 32'd1);
    run_rd(40, 4'd3, "R6");
    run_rd(3, 4'd5, "R5");
    wr(4'd5, 32'hF);
    cyc(4'd5, 1'b0, 32'd0, "R9");

    // R4: counter-clear holds both counters at zero
    wr(4'd0, 32'd3);
    run_rd(4, 4'd3, "R4");
    run_rd(2, 4'd4, "R4");

    // R7: halt on comparator 1 at 3
    wr(4'd1, 32'b101 << 3);
    wr(4'd9, 32'd3);
    wr(4'd2, 32'd0);
    wr(4'd0, 32'd1);
    run_rd(8, 4'd0, "R7");
    run_rd(2, 4'd3, "R7");

    // R3: disabled counters keep value
    run_rd(4, 4'd4, "R3");
    run_rd(4, 4'd3, "R3");

    // R8: comparator 2 halts and comparator 3 restarts at the same value
    wr(4'd0, 32'd2);
    wr(4'd10, 32'd4);
    wr(4'd11, 32'd4);
    wr(4'd1, (32'b100 << 6) | (32'b011 << 9));
    wr(4'd0, 32'd1);
    run_rd(8, 4'd3, "R8");
    cyc(4'd0, 1'b0, 32'd0, "R8");

    // R9: clear write on a setting clock keeps the flag
    wr(4'd0, 32'd2);
    wr(4'd5, 32'hF);
    wr(4'd8, 32'd0);
    wr(4'd1, 32'b001);
    wr(4'd0, 32'd1);
    cyc(4'd5, 1'b1, 32'h1, "R9");
    cyc(4'd5, 1'b0, 32'd0, "R9");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic we;
      logic [31:0] d;
      int sel = $urandom_range(0, 10);
      a = (sel <= 5) ? 4'(sel) : (sel == 10 ? 4'd6 : 4'(sel + 3));
      we = ($urandom_range(0, 5) == 0);
      d = $urandom;
      case (a)
        4'd0: d = {30'd0, ($urandom_range(0, 3) != 0) ? 2'b01 : d[1:0]};
        4'd2: d = 32'($urandom_range(0, 3));
        4'd8, 4'd9, 4'd10, 4'd11: d = 32'($urandom_range(0, 12));
        default: ;
      endcase
      cyc(a, we, d, "");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule